// File: doc/BRIEF.md
# Inter-Processor and Interval Timer Control

This block keeps the shared control word that four processors use to signal each other and to see interval-timer events. It also keeps one tick-skip counter per processor. Software reaches both through a 64-bit register port. A write to the control word applies a different rule to each field. Some bits are cleared by writing ones, some are set by writing ones, one field accepts ones only while it is empty, one bit empties two fields, and one field is plain storage. The block drives one inter-processor interrupt level and one timer interrupt level per processor.

A periodic tick comes from outside the block. It is resynchronized and edge-detected. Each rising edge decrements the counter of every processor marked present. A counter that wraps below zero keeps a sticky overflow flag. While that flag is set, every tick raises the processor's timer bit in the control word and its timer interrupt. Software gives a processor some ticks to skip by loading a count, and it acknowledges a timer interrupt by clearing the timer bit.

Top module: `ipt_ctl`

## Requirements
- R1: A read at offset 0x080 returns the control word with the requester's 2-bit processor id ORed into bits 1:0. Reset value of the word is 0x0000_0008_0000_0000, with the revision flag in bit 35. No write changes bit 35.
- R2: In a control word write, each data bit that is set among bits 11:4 clears the stored bit in the same position. Bits 7:4 are the timer bits of processors 0-3 and bits 11:8 are the IPI bits.
- R3: A control word write with data bit 20 set clears stored bits 23:16.
- R4: When data bit 20 is clear, data bits 23:20 are ORed into stored bits 23:20. Data bits 19:16 are ORed in only if stored bits 19:16 are all zero before the write.
- R5: Data bits 15:12 of a control word write set IPI bits 11:8, and this takes priority over a clear of the same bit in the same write. `ipi_o[i]` equals stored bit 8+i.
- R6: Every control word write copies data bits 43:40 into stored bits 43:40.
- R7: The counters are at offsets 0x380, 0x3C0, 0x700 and 0x740 for processors 0-3. A write keeps data bits 23:0 and clears overflow bit 24. A read returns the 25-bit value in bits 24:0.
- R8: On each tick event, the counter of each processor with `cpu_present[i]` high decrements modulo 2^25, and its bit 24 stays set once set. The counters of absent processors do not change. A counter write in the same cycle as a tick takes precedence over the tick.
- R9: After a tick event leaves a counter with bit 24 set, stored bit 4+i and `timer_irq_o[i]` are set. `timer_irq_o[i]` follows stored bit 4+i, and no register write can set either.
- R10: Each low-to-high transition of `tick_in` gives exactly one tick event, however long the input stays high. Falling edges have no effect. The event updates the counters on the third rising clock edge after `tick_in` rises.
- R11: Reset clears all counters and all IPI and timer outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register offset |
| csr_wdata | input | 64 | Write data |
| csr_cpu | input | 2 | Id of the requesting processor |
| csr_rdata | output | 64 | Read data for `csr_addr`, combinational |
| tick_in | input | 1 | Periodic tick, asynchronous |
| cpu_present | input | 4 | Marks which processors exist |
| ipi_o | output | 4 | Inter-processor interrupt level per processor |
| timer_irq_o | output | 4 | Timer interrupt level per processor |

## Verification
The state hardest to reach is a counter that has already overflowed and is then ticked again after software cleared its timer bit. The sticky flag must set the interrupt again even though the count has moved well past the wrap. The stimulus loads one counter at zero and one at a small count, ticks until both wrap, clears the timer bits with ones-writes, and ticks once more. It also holds the tick high for many cycles to show that only one decrement follows, and it writes the second arbitration field while it is occupied and again after the clear bit has emptied it.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int N_CPU   = 4;
  localparam int ADDR_W  = 12;
  localparam int IIC_W   = 24;
  localparam int ITI_LSB = 4;
  localparam int IPI_LSB = 8;
  localparam int REQ_LSB = 12;
  localparam int ABW_LSB = 16;
  localparam int ABT_LSB = 20;
  localparam int CLR_BIT = 20;
  localparam int RW_LSB  = 40;

  localparam logic [ADDR_W-1:0] MISC_OFS   = 12'h080;
  localparam logic [63:0]       MISC_RESET = 64'h0000_0008_0000_0000;
  localparam logic [63:0]       W1C_MASK   = 64'h0000_0000_1000_0FF0;

  // Offset of processor i's tick-skip counter
  function automatic logic [ADDR_W-1:0] iic_offset(input int i);
    if (i < 2) return ADDR_W'(12'h380 + i * 12'h40);
    else       return ADDR_W'(12'h700 + (i - 2) * 12'h40);
  endfunction

  // Per-field write rules of the control word
  function automatic logic [63:0] misc_wr_apply(input logic [63:0] cur,
                                                input logic [63:0] w);
    logic [63:0] n;
    n = cur & ~(w & W1C_MASK);
    if (w[CLR_BIT]) begin
      n[ABW_LSB +: 8] = '0;
    end else begin
      n[ABT_LSB +: 4] = n[ABT_LSB +: 4] | w[ABT_LSB +: 4];
      if (cur[ABW_LSB +: 4] == 4'b0)
        n[ABW_LSB +: 4] = w[ABW_LSB +: 4];
    end
    n[IPI_LSB +: 4] = n[IPI_LSB +: 4] | w[REQ_LSB +: 4];
    n[RW_LSB +: 4]  = w[RW_LSB +: 4];
    return n;
  endfunction

  // One tick: wrap-around decrement with a sticky top bit
  function automatic logic [IIC_W:0] iic_step(input logic [IIC_W:0] c);
    logic [IIC_W:0] d;
    d = c - 1'b1;
    d[IIC_W] = d[IIC_W] | c[IIC_W];
    return d;
  endfunction
endpackage

// File: rtl/ipt_tick_sync.sv
module ipt_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_evt
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], tick_in};
  end

  assign tick_evt = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R10
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> !tick_evt);
endmodule

// File: rtl/ipt_ignore_cnt.sv
module ipt_ignore_cnt
  import ipt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IIC_W-1:0] wdata,
  input  logic             tick_evt,
  input  logic             present,
  output logic [IIC_W:0]   cnt_q,
  output logic             ovf_set
);
  logic [IIC_W:0] step;
  logic           do_tick;

  assign step    = iic_step(cnt_q);
  assign do_tick = tick_evt & present & ~wr_en;
  assign ovf_set = do_tick & step[IIC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_en)   cnt_q <= {1'b0, wdata};
    else if (do_tick) cnt_q <= step;
  end

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q[IIC_W]) && !$past(wr_en)) |-> cnt_q[IIC_W]);

  // R7
  wr_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> !cnt_q[IIC_W]);

  // R8
  absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!present && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/ipt_misc_reg.sv
module ipt_misc_reg
  import ipt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [63:0]      wdata,
  input  logic [N_CPU-1:0] tick_set,
  output logic [63:0]      misc_q,
  output logic [N_CPU-1:0] ipi_o,
  output logic [N_CPU-1:0] tirq_o
);
  logic [63:0] wr_val;
  logic [63:0] misc_d;

  assign wr_val = wr_en ? misc_wr_apply(misc_q, wdata) : misc_q;

  always_comb begin
    misc_d = wr_val;
    misc_d[ITI_LSB +: N_CPU] = wr_val[ITI_LSB +: N_CPU] | tick_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= MISC_RESET;
      tirq_o <= '0;
    end else begin
      misc_q <= misc_d;
      tirq_o <= (tirq_o | tick_set) & misc_d[ITI_LSB +: N_CPU];
    end
  end

  assign ipi_o = misc_q[IPI_LSB +: N_CPU];

  // R9
  iti_only_by_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_q[ITI_LSB +: N_CPU] & ~$past(misc_q[ITI_LSB +: N_CPU])
      & ~$past(tick_set)) == '0);

  // R1
  rev_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(misc_q[35]));

  // R4
  abw_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_q[ABW_LSB +: 4] != $past(misc_q[ABW_LSB +: 4])) |->
      ($past(misc_q[ABW_LSB +: 4]) == 4'b0 || misc_q[ABW_LSB +: 4] == 4'b0));

  // R9
  tirq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tirq_o == misc_q[ITI_LSB +: N_CPU]);
endmodule

// File: rtl/ipt_ctl.sv
module ipt_ctl
  import ipt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  input  logic [1:0]        csr_cpu,
  output logic [63:0]       csr_rdata,
  input  logic              tick_in,
  input  logic [N_CPU-1:0]  cpu_present,
  output logic [N_CPU-1:0]  ipi_o,
  output logic [N_CPU-1:0]  timer_irq_o
);
  logic             tick_evt;
  logic             misc_hit;
  logic [63:0]      misc_q;
  logic [N_CPU-1:0] tick_set;
  logic [IIC_W:0]   cnt_q [N_CPU];

  assign misc_hit = csr_we && (csr_addr == MISC_OFS);

  ipt_tick_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_evt(tick_evt)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_cnt
    localparam logic [ADDR_W-1:0] OFS = iic_offset(g);
    logic hit;
    assign hit = csr_we && (csr_addr == OFS);
    ipt_ignore_cnt u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(hit), .wdata(csr_wdata[IIC_W-1:0]),
      .tick_evt(tick_evt), .present(cpu_present[g]),
      .cnt_q(cnt_q[g]), .ovf_set(tick_set[g])
    );
  end

  ipt_misc_reg u_misc (
    .clk(clk), .rst_n(rst_n), .wr_en(misc_hit), .wdata(csr_wdata),
    .tick_set(tick_set), .misc_q(misc_q), .ipi_o(ipi_o), .tirq_o(timer_irq_o)
  );

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == MISC_OFS) csr_rdata = misc_q | {62'b0, csr_cpu};
    for (int i = 0; i < N_CPU; i++)
      if (csr_addr == iic_offset(i)) csr_rdata = {{(63-IIC_W){1'b0}}, cnt_q[i]};
  end

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (ipi_o == '0 && timer_irq_o == '0));
endmodule

// File: tb/sim_ipt_ctl.sv
`timescale 1ns/1ps
module sim_ipt_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  csr_cpu = '0;
  logic [63:0] csr_rdata;
  logic        tick_in = 1'b0;
  logic [3:0]  cpu_present = 4'b0111;
  logic [3:0]  ipi_o, timer_irq_o;

  always #2.5 clk = ~clk;

  ipt_ctl u0 (.*);

  int tests = 0, fails = 0;

  // Behavioural reference: fields kept separately
  bit [3:0] m_ipi, m_iti, m_abt, m_abw, m_rw;
  int       m_cnt [4];
  bit       m_of  [4];
  bit       t1, t2, t3;

  function automatic int ofs_cpu(input logic [11:0] a);
    case (a)
      12'h380: return 0;
      12'h3C0: return 1;
      12'h700: return 2;
      12'h740: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] m_read(input logic [11:0] a, input logic [1:0] c);
    int k;
    if (a == 12'h080)
      return (64'(m_rw) << 40) | (64'h1 << 35) | (64'(m_abt) << 20) |
             (64'(m_abw) << 16) | (64'(m_ipi) << 8) | (64'(m_iti) << 4) | 64'(c);
    k = ofs_cpu(a);
    if (k < 0) return 64'h0;
    return (64'(m_of[k]) << 24) | 64'(m_cnt[k]);
  endfunction

  always @(posedge clk) begin
    bit pulse;
    int k;
    if (!rst_n) begin
      m_ipi = 0; m_iti = 0; m_abt = 0; m_abw = 0; m_rw = 0;
      t1 = 0; t2 = 0; t3 = 0;
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_of[i] = 0; end
    end else begin
      pulse = t2 && !t3;
      t3 = t2; t2 = t1; t1 = tick_in;
      if (csr_we && csr_addr == 12'h080) begin
        m_iti = m_iti & ~csr_wdata[7:4];
        m_ipi = (m_ipi & ~csr_wdata[11:8]) | csr_wdata[15:12];
        if (csr_wdata[20]) begin m_abt = 0; m_abw = 0; end
        else begin
          m_abt = m_abt | csr_wdata[23:20];
          if (m_abw == 0) m_abw = csr_wdata[19:16];
        end
        m_rw = csr_wdata[43:40];
      end
      k = csr_we ? ofs_cpu(csr_addr) : -1;
      for (int i = 0; i < 4; i++) begin
        if (k == i) begin
          m_cnt[i] = int'(csr_wdata[23:0]); m_of[i] = 0;
        end else if (pulse && cpu_present[i]) begin
          if (m_cnt[i] == 0) begin m_cnt[i] = 24'hFFFFFF; m_of[i] = 1; end
          else m_cnt[i] = m_cnt[i] - 1;
          if (m_of[i]) m_iti[i] = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison of the interrupt levels
  always @(negedge clk) begin
    check("R5 ipi_o", 64'(ipi_o), 64'(m_ipi));
    check("R9 timer_irq_o", 64'(timer_irq_o), 64'(m_iti));
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0; csr_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [1:0] c);
    @(negedge clk); csr_addr = a; csr_cpu = c; #1;
    check(tag, csr_rdata, m_read(a, c));
  endtask

  task automatic rd_lit(input string tag, input logic [11:0] a, input logic [1:0] c,
                        input logic [63:0] exp);
    @(negedge clk); csr_addr = a; csr_cpu = c; #1;
    check(tag, csr_rdata, exp);
  endtask

  task automatic tick(input int hi, input int lo);
    @(negedge clk); tick_in = 1;
    repeat (hi) @(negedge clk);
    tick_in = 0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset ipi", 64'(ipi_o), 64'h0);
    check("R11 reset timer", 64'(timer_irq_o), 64'h0);
    rst_n = 1;
    rd_lit("R1 reset word", 12'h080, 2'd0, 64'h0000_0008_0000_0000);
    rd_lit("R1 cpu id", 12'h080, 2'd3, 64'h0000_0008_0000_0003);
    rd_lit("R11 counter zero", 12'h740, 2'd0, 64'h0);

    wr(12'h080, 64'h0000_0000_0000_F000);
    rd_lit("R5 ipi set", 12'h080, 2'd2, 64'h0000_0008_0000_0F02);
    wr(12'h080, 64'h0000_0000_0000_0500);
    check("R2 ipi w1c", 64'(ipi_o), 64'hA);
    wr(12'h080, 64'h0000_0000_0000_1100);
    check("R5 set beats clear", 64'(ipi_o), 64'hB);
    wr(12'h080, 64'h0000_0000_00A3_0000);
    rd_lit("R4 arb set", 12'h080, 2'd1, 64'h0000_0008_00A3_0B01);
    wr(12'h080, 64'h0000_0000_000C_0000);
    rd("R4 abw occupied", 12'h080, 2'd0);
    wr(12'h080, 64'h0000_0000_0050_0000);
    rd("R4 abt ones", 12'h080, 2'd0);
    wr(12'h080, 64'h0000_0000_0010_0000);
    rd("R3 arb clear", 12'h080, 2'd0);
    wr(12'h080, 64'h0000_0000_000C_0000);
    rd("R4 abw empty", 12'h080, 2'd0);
    wr(12'h080, 64'h0000_0A00_0000_0000);
    rd("R6 rw field", 12'h080, 2'd0);
    wr(12'h080, 64'h0000_05F7_0000_0000);
    rd("R6 rw rewrite, R1 rev kept", 12'h080, 2'd1);

    wr(12'h380, 64'h0000_0000_0000_0003);
    wr(12'h700, 64'h0000_0000_01FF_FFFF);
    rd_lit("R7 write drops bit24", 12'h700, 2'd0, 64'h0000_0000_00FF_FFFF);
    repeat (4) tick(2, 5);
    rd_lit("R8 cnt0 wrapped", 12'h380, 2'd0, 64'h0000_0000_01FF_FFFF);
    rd_lit("R8 cnt1 sticky", 12'h3C0, 2'd0, 64'h0000_0000_01FF_FFFC);
    rd_lit("R8 cnt2", 12'h700, 2'd0, 64'h0000_0000_00FF_FFFB);
    rd_lit("R8 absent cpu3", 12'h740, 2'd0, 64'h0);
    check("R9 timer after wrap", 64'(timer_irq_o), 64'h3);

    tick(20, 5);
    rd_lit("R10 held tick once", 12'h700, 2'd0, 64'h0000_0000_00FF_FFFA);

    wr(12'h080, 64'h0000_0000_0000_0010);
    check("R9 w1c drops irq0", 64'(timer_irq_o), 64'h2);
    wr(12'h080, 64'h0000_0000_0000_0000);
    check("R9 write cannot set", 64'(timer_irq_o), 64'h2);
    wr(12'h080, 64'h0000_0000_0000_00F0);
    check("R2 timer w1c all", 64'(timer_irq_o), 64'h0);
    tick(2, 5);
    check("R9 sticky re-raise", 64'(timer_irq_o), 64'h3);

    wr(12'h380, 64'h0000_0000_0000_0005);
    rd_lit("R7 reload", 12'h380, 2'd0, 64'h5);
    wr(12'h080, 64'h0000_0000_0000_0030);
    tick(2, 5);
    check("R9 reloaded no irq0", 64'(timer_irq_o), 64'h2);
    rd("R8 after reload tick", 12'h380, 2'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule